// File: doc/BRIEF.md
# Asymmetric Switch Debouncer

This block cleans up a mechanical switch input whose two edges need different treatment. The raw input first passes through a clock-domain synchronizer. After that, the synchronized value is examined only on cycles where a sample tick is asserted. The tick comes from an external divider that sets the sampling rate.

A change from low to high must be confirmed: the input has to read high on `QUAL_N` consecutive ticks before it counts. A change from high to low is accepted on the first tick that reads low.

The application sees three outputs:
- a debounced level;
- a one-cycle rise pulse;
- a one-cycle fall pulse.

A mode input chooses when the rise is reported:
- **Late mode.** The rise is reported when confirmation completes.
- **Early mode.** The rise is reported on the very first high tick. If confirmation then fails, a fall pulse is issued so that every reported rise has a matching fall.

The mode is captured when each confirmation attempt begins.

Top module: `asym_debounce`

## Requirements
- R1: After reset the level output is 0, and the rise and fall pulses are 0.
- R2: In late mode (early_rpt_i = 0), a high sample taken on a tick while the level is low gives no rise pulse, and the level stays 0.
- R3: In late mode, the tick carrying the QUAL_N-th consecutive high sample raises the level to 1. The rise pulse is 1 in the clock cycle that follows that tick's clock edge, and 0 in the cycle after.
- R4: A low sample during confirmation cancels it with no rise, even on the tick that would have been the last. A later attempt again needs QUAL_N consecutive high ticks.
- R5: From a confirmed high level, one low tick drives the level to 0 and produces a one-cycle fall pulse.
- R6: In early mode (early_rpt_i = 1), the first high tick produces the rise pulse and sets the level to 1. Completing confirmation produces no second rise.
- R7: In early mode, a low tick during confirmation produces a fall pulse and returns the level to 0.
- R8: Input changes on cycles without a tick have no effect on the level or on the pulses.
- R9: The mode is taken from early_rpt_i on the tick that starts confirmation. Changing early_rpt_i later in the same attempt does not alter how that attempt is reported.
- R10: Rise and fall are never asserted in the same cycle, and neither pulse lasts longer than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Sample enable, one clock wide |
| raw_i | input | 1 | Unsynchronized switch input |
| early_rpt_i | input | 1 | 1 = report the rise at the start of confirmation |
| level_o | output | 1 | Debounced level |
| rise_o | output | 1 | Rising event pulse |
| fall_o | output | 1 | Falling event pulse |

## Verification
Two decisions can land on the same tick.

The first pair is completion of confirmation and cancellation. The bench gives QUAL_N-1 high ticks and then presents a low sample on the tick that would have completed confirmation. It expects neither a rise nor a raised level.

The second pair is the start of confirmation and the mode capture. The bench flips early_rpt_i in the middle of an attempt. It judges the outcome by where the rise or fall pulse appears: at completion for an attempt started in late mode, and at cancellation for an attempt started in early mode.

// File: rtl/deb_pkg.sv
package deb_pkg;
   typedef enum logic [1:0] {
      ST_LOW  = 2'd0,
      ST_QUAL = 2'd1,
      ST_HIGH = 2'd2
   } deb_state_t;
endpackage

// File: rtl/deb_sync.sv
module deb_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 1) begin : g_bad
      $error("deb_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      logic ff_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ff_q <= 1'b0;
         else        ff_q <= d_i;
      end
      assign q_o = ff_q;
   end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= {chain_q[STAGES-2:0], d_i};
      end
      assign q_o = chain_q[STAGES-1];
   end
endmodule

// File: rtl/deb_qual_cnt.sv
module deb_qual_cnt #(
   parameter int QUAL_N = 20,
   localparam int CNT_W = $clog2(QUAL_N + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             step_i,
   input  logic             clr_i,
   output logic             last_o,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(QUAL_N - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (clr_i)   cnt_q <= '0;
      else if (start_i) cnt_q <= CNT_W'(1);
      else if (step_i)  cnt_q <= cnt_q + CNT_W'(1);
   end

   assign last_o = (cnt_q == LAST_VAL);
   assign cnt_o  = cnt_q;

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < CNT_W'(QUAL_N)); // R4

   AST_STEP_NOT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      step_i |-> !last_o); // R3
endmodule

// File: rtl/asym_debounce.sv
module asym_debounce
   import deb_pkg::*;
#(
   parameter int QUAL_N      = 20,
   parameter int SYNC_STAGES = 2,
   localparam int CNT_W      = $clog2(QUAL_N + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic raw_i,
   input  logic early_rpt_i,
   output logic level_o,
   output logic rise_o,
   output logic fall_o
);
   if (QUAL_N < 2) begin : g_bad_n
      $error("asym_debounce: QUAL_N must be at least 2");
   end

   logic             samp;
   logic             cnt_last;
   logic [CNT_W-1:0] cnt_val;
   logic             cnt_start, cnt_step, cnt_clr;
   deb_state_t       state_q, state_d;
   logic             early_q;
   logic             rise_d, fall_d;
   logic             rise_q, fall_q;

   deb_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_i),
      .q_o   (samp)
   );

   deb_qual_cnt #(.QUAL_N(QUAL_N)) i_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (cnt_start),
      .step_i  (cnt_step),
      .clr_i   (cnt_clr),
      .last_o  (cnt_last),
      .cnt_o   (cnt_val)
   );

   always_comb begin
      state_d   = state_q;
      rise_d    = 1'b0;
      fall_d    = 1'b0;
      cnt_start = 1'b0;
      cnt_step  = 1'b0;
      cnt_clr   = 1'b0;
      if (tick_i) begin
         unique case (state_q)
            ST_LOW: begin
               if (samp) begin
                  state_d   = ST_QUAL;
                  cnt_start = 1'b1;
                  rise_d    = early_rpt_i;
               end
            end
            ST_QUAL: begin
               if (!samp) begin
                  state_d = ST_LOW;
                  cnt_clr = 1'b1;
                  fall_d  = early_q;
               end else if (cnt_last) begin
                  state_d = ST_HIGH;
                  cnt_clr = 1'b1;
                  rise_d  = !early_q;
               end else begin
                  cnt_step = 1'b1;
               end
            end
            ST_HIGH: begin
               if (!samp) begin
                  state_d = ST_LOW;
                  fall_d  = 1'b1;
               end
            end
            default: state_d = ST_LOW;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_LOW;
         early_q <= 1'b0;
         rise_q  <= 1'b0;
         fall_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         rise_q  <= rise_d;
         fall_q  <= fall_d;
         if (cnt_start) early_q <= early_rpt_i;
      end
   end

   assign level_o = (state_q == ST_HIGH) || ((state_q == ST_QUAL) && early_q);
   assign rise_o  = rise_q;
   assign fall_o  = fall_q;

   AST_RISE_FALL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise_o && fall_o)); // R10

   AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o); // R10

   AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o |=> !fall_o); // R10

   AST_RISE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |-> level_o); // R3

   AST_FALL_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o |-> !level_o); // R5

   AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> ($stable(level_o) && !rise_o && !fall_o)); // R8

   AST_HIGH_FROM_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_HIGH && $past(state_q) != ST_HIGH) |-> $past(cnt_last)); // R3
endmodule

// File: tb/test_asym_debounce.sv
`timescale 1ns/1ps
module test_asym_debounce;
   localparam int N = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_i = 1'b0;
   logic raw_i = 1'b0;
   logic early_rpt_i = 1'b0;
   logic level_o, rise_o, fall_o;

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   asym_debounce #(.QUAL_N(N)) i_asym_debounce (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_i      (tick_i),
      .raw_i       (raw_i),
      .early_rpt_i (early_rpt_i),
      .level_o     (level_o),
      .rise_o      (rise_o),
      .fall_o      (fall_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic set_raw(input logic v);
      @(negedge clk) raw_i = v;
      repeat (4) @(negedge clk);
   endtask

   // one tick; on return outputs reflect that tick's edge (sampled at negedge)
   task automatic do_tick();
      @(negedge clk) tick_i = 1'b1;
      @(negedge clk) tick_i = 1'b0;
   endtask

   task automatic t_reset();
      check(level_o == 0, "R1 level", level_o, 0);
      check(rise_o == 0 && fall_o == 0, "R1 pulses", {rise_o, fall_o}, 0);
   endtask

   task automatic t_late_rise();
      early_rpt_i = 1'b0;
      set_raw(1);
      do_tick();
      check(rise_o == 0, "R2 no rise on first high", rise_o, 0);
      check(level_o == 0, "R2 level low", level_o, 0);
      for (int k = 2; k < N; k++) begin
         do_tick();
         check(rise_o == 0 && level_o == 0, "R3 not yet confirmed", {rise_o, level_o}, 0);
      end
      do_tick();
      check(rise_o == 1, "R3 rise at Nth tick", rise_o, 1);
      check(level_o == 1, "R3 level high", level_o, 1);
      @(negedge clk);
      check(rise_o == 0, "R3 rise one cycle", rise_o, 0);
   endtask

   task automatic t_fall();
      set_raw(0);
      do_tick();
      check(fall_o == 1, "R5 fall pulse", fall_o, 1);
      check(level_o == 0, "R5 level low", level_o, 0);
      @(negedge clk);
      check(fall_o == 0, "R5 fall one cycle", fall_o, 0);
   endtask

   task automatic t_abort();
      int rises = 0;
      int falls = 0;
      early_rpt_i = 1'b0;
      set_raw(1);
      for (int k = 0; k < 10; k++) begin
         do_tick();
         rises += rise_o;
      end
      set_raw(0);
      do_tick();
      falls += fall_o;
      check(level_o == 0 && rises == 0 && falls == 0, "R4 abort silent",
            level_o + rises + falls, 0);
      set_raw(1);
      for (int k = 1; k < N; k++) begin
         do_tick();
         rises += rise_o;
      end
      check(level_o == 0 && rises == 0, "R4 restart needs full N", level_o + rises, 0);
      do_tick();
      check(rise_o == 1 && level_o == 1, "R4 restart completes", {rise_o, level_o}, 3);
      t_fall();
   endtask

   task automatic t_abort_at_last();
      int rises = 0;
      set_raw(1);
      for (int k = 1; k < N; k++) begin
         do_tick();
         rises += rise_o;
      end
      set_raw(0);
      do_tick();
      rises += rise_o;
      check(rises == 0, "R4 abort on last tick no rise", rises, 0);
      check(level_o == 0 && fall_o == 0, "R4 abort on last tick level", {level_o, fall_o}, 0);
   endtask

   task automatic t_ignore();
      int pulses = 0;
      @(negedge clk) raw_i = 1'b1;
      for (int k = 0; k < 60; k++) begin
         @(negedge clk);
         pulses += rise_o + fall_o + level_o;
         if (k == 30) raw_i = 1'b0;
         if (k == 40) raw_i = 1'b1;
      end
      check(pulses == 0, "R8 no tick no effect", pulses, 0);
      set_raw(0);
   endtask

   task automatic t_early();
      int rises = 0;
      early_rpt_i = 1'b1;
      set_raw(1);
      do_tick();
      check(rise_o == 1 && level_o == 1, "R6 early rise", {rise_o, level_o}, 3);
      for (int k = 2; k <= N + 2; k++) begin
         do_tick();
         rises += rise_o;
         rises += (level_o == 0) ? 100 : 0;
      end
      check(rises == 0, "R6 no second rise, level held", rises, 0);
      t_fall();
   endtask

   task automatic t_early_abort();
      early_rpt_i = 1'b1;
      set_raw(1);
      do_tick();
      do_tick();
      set_raw(0);
      do_tick();
      check(fall_o == 1, "R7 paired fall on abort", fall_o, 1);
      check(level_o == 0, "R7 level low after abort", level_o, 0);
   endtask

   task automatic t_mode_latch();
      int rises = 0;
      early_rpt_i = 1'b0;
      set_raw(1);
      do_tick();
      rises += rise_o;
      early_rpt_i = 1'b1;
      for (int k = 2; k < N; k++) begin
         do_tick();
         rises += rise_o;
      end
      check(rises == 0 && level_o == 0, "R9 late attempt stays late", rises + level_o, 0);
      do_tick();
      check(rise_o == 1, "R9 late attempt rises at end", rise_o, 1);
      t_fall();
      early_rpt_i = 1'b1;
      set_raw(1);
      do_tick();
      check(rise_o == 1, "R9 early attempt rise", rise_o, 1);
      early_rpt_i = 1'b0;
      do_tick();
      check(level_o == 1, "R9 early attempt level held", level_o, 1);
      set_raw(0);
      do_tick();
      check(fall_o == 1, "R9 early attempt paired fall", fall_o, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_late_rise();
      t_fall();
      t_abort();
      t_abort_at_last();
      t_ignore();
      t_early();
      t_early_abort();
      t_mode_latch();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule